// File: doc/BRIEF.md
# Two-Port Memory with Same-Address Busy Arbitration

This block is a synchronous memory with two fully independent ports, left and right. Each port has an active-low select, an address, a read/write strobe, write data and registered read data. Either port may read or write any word in any cycle. When both ports are selected on the same address in the same cycle, the block picks one port to proceed. It flags the other port with an active-low busy signal, and any write from that port is dropped inside the block.

A mode input sets the role of the busy signals. In master mode the block arbitrates and drives its two busy outputs. In slave mode the block does not arbitrate: its busy outputs stay high, and two busy inputs act only as per-port write inhibits. To widen a memory, several slaves take their inhibits from one master's busy outputs, so every slice agrees on which side loses. The depth is a parameter; the default is kept small and 14 address bits give the full 16K-word array.

Top module: `dpram_busy_arb`

## Requirements
- R1: A selected port reads any word. Its read data changes one clock after the access to the word held before that cycle's writes, and holds its value while the port is deselected.
- R2: Both busy outputs are high whenever either select is high or the two addresses differ.
- R3: In master mode, with both ports selected on the same address, exactly one busy output is low. Both are never low together.
- R4: Arrival is judged per clock. A port whose select was low on the same address in the previous cycle wins over a port that is new this cycle. When both are new in the same cycle, the left port wins and the right port gets busy.
- R5: While both ports stay selected on one unchanged common address, the busy outcome of the previous cycle is kept.
- R6: Arbitration depends only on selects and addresses. The read/write strobes (1 = read, 0 = write) never change the busy outputs.
- R7: In master mode a write from the port whose busy output is low leaves memory unchanged. A read from that port still returns the stored word.
- R8: In slave mode both busy outputs are high. A low busy input blocks writes from that port only, and its reads are unaffected.
- R9: In slave mode with both busy inputs high, both ports write freely. If both write one address in the same cycle, the left data is stored.
- R10: During and right after reset both busy outputs are high and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = slave, busy inputs inhibit writes |
| l_sel_n | input | 1 | Left port select, active low |
| l_addr | input | ADDR_W | Left address |
| l_rnw | input | 1 | Left strobe, 1 = read, 0 = write |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy in master mode, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_addr | input | ADDR_W | Right address |
| r_rnw | input | 1 | Right strobe, 1 = read, 0 = write |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_out_n | output | 1 | Right busy in master mode, active low |

## Verification
The properties assume that both selects are held high while reset is applied, so the previous-cycle history seen by the priority check matches the cleared internal state. They also assume that inputs change only between clock edges, since busy is a combinational function of the current inputs and registered history. The bench drives every input on the falling edge and keeps both selects high throughout reset. It draws addresses from a few words so that collisions, held grants and new arrivals all happen often, in both modes.

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_rnw,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_in_n,
  output logic              l_busy_out_n,
  input  logic              r_sel_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_rnw,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_in_n,
  output logic              r_busy_out_n
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic l_req, r_req, hit;
  logic l_req_q, r_req_q, hit_q, lwin_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic l_old, r_old, keep, lwin;
  logic l_lose, r_lose, l_block, r_block, l_wen, r_wen;

  assign l_req = !l_sel_n;
  assign r_req = !r_sel_n;
  assign hit   = l_req && r_req && (l_addr == r_addr);

  // history: who was already on this address last cycle
  assign l_old = l_req_q && (l_addr_q == l_addr);
  assign r_old = r_req_q && (r_addr_q == r_addr);
  assign keep  = hit_q && (l_addr_q == l_addr) && (r_addr_q == r_addr);

  always_comb begin
    if (keep)                lwin = lwin_q;
    else if (r_old && !l_old) lwin = 1'b0;
    else                     lwin = 1'b1;
  end

  assign l_lose = hit && !lwin;
  assign r_lose = hit && lwin;

  assign l_busy_out_n = !(master_mode && l_lose);
  assign r_busy_out_n = !(master_mode && r_lose);

  assign l_block = master_mode ? l_lose : !l_busy_in_n;
  assign r_block = master_mode ? r_lose : !r_busy_in_n;

  assign l_wen = l_req && !l_rnw && !l_block;
  assign r_wen = r_req && !r_rnw && !r_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_req_q  <= 1'b0;
      r_req_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      hit_q    <= 1'b0;
      lwin_q   <= 1'b1;
    end else begin
      l_req_q  <= l_req;
      r_req_q  <= r_req;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      hit_q    <= hit;
      lwin_q   <= lwin;
    end
  end

  // right first so a same-cycle left write to the same word lands last
  always_ff @(posedge clk) begin
    if (r_wen) mem[r_addr] <= r_wdata;
    if (l_wen) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_req) l_rdata <= mem[l_addr];
      if (r_req) r_rdata <= mem[r_addr];
    end
  end

  assert_quiet_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel_n || r_sel_n || (l_addr != r_addr)) |-> (l_busy_out_n && r_busy_out_n));

  assert_single_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_sel_n && !r_sel_n && (l_addr == r_addr))
      |-> ($countones({l_busy_out_n, r_busy_out_n}) == 1));

  assert_early_left_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_sel_n && !r_sel_n && (l_addr == r_addr)
      && $past(!l_sel_n) && $past(r_sel_n) && $stable(l_addr)) |-> !r_busy_out_n);

  assert_grant_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_sel_n && !r_sel_n && (l_addr == r_addr)
      && $past(!l_sel_n && !r_sel_n && master_mode)
      && $stable(l_addr) && $stable(r_addr) && $past(!l_busy_out_n)) |-> !l_busy_out_n);

  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_out_n && r_busy_out_n));

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> (l_rdata == '0 && r_rdata == '0));
endmodule

// File: tb/dpram_busy_arb_tb.sv
module dpram_busy_arb_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_sel_n = 1'b1, r_sel_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_rnw = 1'b1, r_rnw = 1'b1;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_out_n, r_busy_out_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_busy_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_sel_n(l_sel_n), .l_addr(l_addr), .l_rnw(l_rnw), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_in_n(l_busy_in_n), .l_busy_out_n(l_busy_out_n),
    .r_sel_n(r_sel_n), .r_addr(r_addr), .r_rnw(r_rnw), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_in_n(r_busy_in_n), .r_busy_out_n(r_busy_out_n));

  int total = 0, bad = 0;
  bit finished = 0;

  logic [DW-1:0] mm [1 << AW];
  logic [DW-1:0] exp_l = '0, exp_r = '0;
  string rtag = "R10";
  logic pl_req = 0, pr_req = 0, phit = 0, plwin = 1;
  logic [AW-1:0] pl_addr = '0, pr_addr = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic left_wins(input logic keep, input logic lold, input logic rold);
    if (keep) return plwin;
    if (rold && !lold) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cyc(input logic m,
                     input logic ls, input logic [AW-1:0] la, input logic lw, input logic [DW-1:0] ld, input logic lb,
                     input logic rs, input logic [AW-1:0] ra, input logic rw, input logic [DW-1:0] rd, input logic rb,
                     input string tag);
    logic lreq, rreq, h, keep, lw_, eb_l, eb_r, blk_l, blk_r;
    string bt;
    @(negedge clk);
    chk({rtag, " left read"}, l_rdata, exp_l);
    chk({rtag, " right read"}, r_rdata, exp_r);
    master_mode = m;
    l_sel_n = ls; l_addr = la; l_rnw = lw; l_wdata = ld; l_busy_in_n = lb;
    r_sel_n = rs; r_addr = ra; r_rnw = rw; r_wdata = rd; r_busy_in_n = rb;
    #1;
    lreq = !ls; rreq = !rs;
    h = lreq && rreq && (la == ra);
    keep = phit && (pl_addr == la) && (pr_addr == ra);
    lw_ = left_wins(keep, pl_req && pl_addr == la, pr_req && pr_addr == ra);
    eb_l = !(m && h && !lw_);
    eb_r = !(m && h && lw_);
    if (tag != "") bt = tag;
    else if (!h) bt = "R2";
    else if (keep) bt = "R5";
    else bt = "R4";
    chk({bt, " left busy"}, DW'(l_busy_out_n), DW'(eb_l));
    chk({bt, " right busy"}, DW'(r_busy_out_n), DW'(eb_r));
    total++;
    if (!l_busy_out_n && !r_busy_out_n) begin
      bad++;
      $display("FAIL R3: actual=both busy low expected=at most one");
    end
    blk_l = m ? !eb_l : !lb;
    blk_r = m ? !eb_r : !rb;
    if (lreq) exp_l = mm[la];
    if (rreq) exp_r = mm[ra];
    if (rreq && !rw && !blk_r) mm[ra] = rd;
    if (lreq && !lw && !blk_l) mm[la] = ld;
    pl_req = lreq; pr_req = rreq; pl_addr = la; pr_addr = ra;
    phit = h; plwin = lw_;
    rtag = (tag == "") ? "R1" : tag;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 busy reset", DW'({l_busy_out_n, r_busy_out_n}), DW'(2'b11));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 left rdata reset", l_rdata, '0);
    chk("R10 right rdata reset", r_rdata, '0);
    rtag = "R10";
    // preload the words used by the run
    for (int a = 0; a < 16; a++)
      cyc(1, 0, AW'(a), 0, DW'(16'h1000 + a), 1, 1, '0, 1, '0, 1, "R1");
    // left arrives first, right joins
    cyc(1, 0, 5, 1, 0, 1, 1, 0, 1, 0, 1, "R4");
    cyc(1, 0, 5, 1, 0, 1, 0, 5, 1, 0, 1, "R4");
    cyc(1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R2");
    // right arrives first, left joins
    cyc(1, 1, 0, 1, 0, 1, 0, 6, 1, 0, 1, "R4");
    cyc(1, 0, 6, 1, 0, 1, 0, 6, 1, 0, 1, "R4");
    // held outcome
    cyc(1, 0, 6, 1, 0, 1, 0, 6, 1, 0, 1, "R5");
    cyc(1, 0, 6, 0, 16'hAAAA, 1, 0, 6, 1, 0, 1, "R5");
    cyc(1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R2");
    // same-cycle tie: left wins, with both read and write strobes
    cyc(1, 0, 7, 1, 0, 1, 0, 7, 1, 0, 1, "R4");
    cyc(1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R2");
    cyc(1, 0, 7, 0, 16'h7777, 1, 0, 7, 0, 16'h8888, 1, "R6");
    cyc(1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R6");
    cyc(1, 0, 7, 1, 0, 1, 0, 7, 1, 0, 1, "R6");
    // busy right write dropped, busy read still returns stored word
    cyc(1, 0, 3, 1, 0, 1, 1, 0, 1, 0, 1, "R7");
    cyc(1, 0, 3, 1, 0, 1, 0, 3, 0, 16'hDEAD, 1, "R7");
    cyc(1, 0, 3, 1, 0, 1, 0, 3, 1, 0, 1, "R7");
    cyc(1, 1, 0, 1, 0, 1, 0, 3, 1, 0, 1, "R7");
    cyc(1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R7");
    // slave: left inhibited, right free
    cyc(0, 0, 9, 0, 16'hBAD0, 0, 0, 10, 0, 16'h600D, 1, "R8");
    cyc(0, 0, 9, 1, 0, 0, 0, 10, 1, 0, 1, "R8");
    cyc(0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R8");
    // slave: both free, same word, left data kept
    cyc(0, 0, 11, 0, 16'h1111, 1, 0, 11, 0, 16'h2222, 1, "R9");
    cyc(0, 0, 11, 1, 0, 1, 0, 11, 1, 0, 1, "R9");
    cyc(0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R9");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic m, ls, rs;
      logic [AW-1:0] la, ra;
      m  = ((i / 500) % 3) != 2;
      ls = ($urandom % 4) == 0;
      rs = ($urandom % 4) == 0;
      la = ($urandom % 2) ? l_addr : AW'($urandom % 4);
      ra = ($urandom % 2) ? r_addr : AW'($urandom % 4);
      cyc(m, ls, la, 1'($urandom), DW'($urandom), ($urandom % 3) != 0,
             rs, ra, 1'($urandom), DW'($urandom), ($urandom % 3) != 0, "");
    end
    cyc(1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1, "R1");
    @(negedge clk);
    chk({rtag, " left read"}, l_rdata, exp_l);
    chk({rtag, " right read"}, r_rdata, exp_r);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule